// File: doc/BRIEF.md
# Repeating Parallel Waveform Streamer

The block plays a stored pattern of wide samples onto a parallel output bus, one sample for each cycle in which the sample-rate enable is high. The output is arranged as a frame of rows. Each row holds a programmed number of active samples, followed by a horizontal blanking gap. Each frame holds a programmed number of active rows, followed by blanking rows. A line strobe marks the start of every horizontal gap, and a frame strobe marks the first rows of the vertical gap. During both gaps the data bus is held at zero.

Software first writes the timing values through a small register-write port and then sets the run bit. From then on the frame repeats without further action. The sample memory is read through a plain address/data port. The block is output only.

Timing values take effect only at a frame boundary. This means a frame is never torn by a write made in the middle of it.

Top module: `wave_streamer`

## Requirements
- R1: In an active position (column below the active-sample count and row below the active-row count), `pix_out` shows the memory word at `mem_addr`. The address starts at 0 on each frame and rises by one, modulo 2^ADDR_W, after each active sample.
- R2: Position, address and outputs move by exactly one step per cycle in which `pix_en` is high. With `pix_en` low, all of them hold.
- R3: `line_strb` is high for the strobe-width count of samples that directly follow the last active sample of every row, including rows in vertical blanking. It is cut off at the end of the row.
- R4: `frame_strb` is high for every sample of the rows that follow the last active row, for the frame-strobe count of rows. It is cut off at the end of the frame.
- R5: `pix_out` is zero at every blanking position, both horizontal and vertical.
- R6: After the last blanking position of the frame, the next frame starts at row 0, column 0 and address 0. This repeats for as long as run is set.
- R7: Timing values written while running are used only from the next frame start. While stopped, written values are taken up at once.
- R8: After reset, and while the run bit is clear, `pix_out`, `line_strb`, `frame_strb` and `mem_addr` are all zero, and the position returns to the frame start.
- R9: Register selects (`cfg_sel`): 0 run (bit 0), 1 active samples per row, 2 horizontal blanking length, 3 line strobe width, 4 active rows, 5 vertical blanking rows, 6 frame strobe width in rows. A write to select 7 changes nothing. Active counts and horizontal blanking must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 12 | Register write value |
| pix_en | input | 1 | Sample-rate enable |
| mem_rdata | input | DATA_W (24) | Sample word at `mem_addr` |
| mem_addr | output | ADDR_W (12) | Sample memory read address |
| pix_out | output | DATA_W (24) | Parallel sample output |
| line_strb | output | 1 | Horizontal strobe |
| frame_strb | output | 1 | Vertical strobe |

## Verification
The bench covers several corner cases, each with the fault it would expose:
- A timing write in the middle of a frame. A design that took new values straight away would change the row length partway through the frame.
- An enable that is high only every third cycle. A design that ignored it would run three times too fast and lose its place.
- A frame larger than the sample memory. This checks that the address wraps modulo its width yet still restarts at 0 on each new frame; an address counter that failed to clear would drift frame by frame.
- A strobe width larger than its blanking gap, and zero vertical blanking. These show whether the strobes stay inside the gap or spill into active data.
- Stopping in the middle of a row, and a write to the unused select. These expose a block that keeps driving after stop, or one that decodes a stray address as the run bit.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
  parameter int unsigned CNT_W = 12;
  localparam int unsigned POS_W = CNT_W + 1;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_H_ACT   = 3'd1,
    SEL_H_BLANK = 3'd2,
    SEL_H_STRB  = 3'd3,
    SEL_V_ACT   = 3'd4,
    SEL_V_BLANK = 3'd5,
    SEL_V_STRB  = 3'd6
  } cfg_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] h_act;
    logic [CNT_W-1:0] h_blank;
    logic [CNT_W-1:0] h_strb;
    logic [CNT_W-1:0] v_act;
    logic [CNT_W-1:0] v_blank;
    logic [CNT_W-1:0] v_strb;
  } timing_t;

  localparam timing_t CFG_RESET = '{
    h_act:   CNT_W'(1),
    h_blank: CNT_W'(1),
    h_strb:  '0,
    v_act:   CNT_W'(1),
    v_blank: CNT_W'(1),
    v_strb:  '0
  };
endpackage

// File: rtl/wvs_cfg_regs.sv
module wvs_cfg_regs
  import wvs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             load_shadow,
  output logic             run,
  output timing_t          active_cfg
);
  timing_t live_q, live_d, shad_d;
  logic    run_d;

  // next-state: live registers take writes, shadow copies live at frame start
  always_comb begin
    live_d = live_q;
    run_d  = run;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL:    run_d          = cfg_wdata[0];
        SEL_H_ACT:   live_d.h_act   = cfg_wdata;
        SEL_H_BLANK: live_d.h_blank = cfg_wdata;
        SEL_H_STRB:  live_d.h_strb  = cfg_wdata;
        SEL_V_ACT:   live_d.v_act   = cfg_wdata;
        SEL_V_BLANK: live_d.v_blank = cfg_wdata;
        SEL_V_STRB:  live_d.v_strb  = cfg_wdata;
        default:     ;
      endcase
    end
    shad_d = load_shadow ? live_q : active_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      live_q     <= CFG_RESET;
      active_cfg <= CFG_RESET;
    end else begin
      run        <= run_d;
      live_q     <= live_d;
      active_cfg <= shad_d;
    end
  end
endmodule

// File: rtl/wvs_axis.sv
// One timing axis: active span, blanking span, strobe at start of blanking.
module wvs_axis
  import wvs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [CNT_W-1:0] n_act,
  input  logic [CNT_W-1:0] n_blank,
  input  logic [CNT_W-1:0] n_strb,
  output logic             in_act,
  output logic             in_strb,
  output logic             at_last
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] act_end, strb_end, last_pos;

  always_comb begin
    act_end  = {1'b0, n_act};
    strb_end = {1'b0, n_act} + {1'b0, n_strb};
    last_pos = {1'b0, n_act} + {1'b0, n_blank} - POS_W'(1);
    in_act   = pos_q < act_end;
    in_strb  = (pos_q >= act_end) && (pos_q < strb_end);
    at_last  = pos_q == last_pos;
  end

  always_comb begin
    pos_d = pos_q;
    if (!run)        pos_d = '0;
    else if (adv)    pos_d = at_last ? '0 : pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/wvs_addr_gen.sv
module wvs_addr_gen #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  logic              in_active,
  input  logic              frame_end,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (!run)                  addr_d = '0;
    else if (step && frame_end) addr_d = '0;
    else if (step && in_active) addr_d = addr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end
endmodule

// File: rtl/wave_streamer.sv
module wave_streamer
  import wvs_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              pix_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] pix_out,
  output logic              line_strb,
  output logic              frame_strb
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic    run_q, step, load_shadow, frame_wrap;
  timing_t cfg;
  logic    h_act, h_strb, h_last, v_act, v_strb, v_last;
  logic    in_active, frame_end;

  assign step        = run_q & pix_en;
  assign in_active   = h_act & v_act;
  assign frame_end   = h_last & v_last;
  assign frame_wrap  = step & frame_end;
  assign load_shadow = ~run_q | frame_wrap;

  wvs_cfg_regs u_cfg (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .load_shadow (load_shadow),
    .run         (run_q),
    .active_cfg  (cfg)
  );

  wvs_axis u_h_axis (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run_q),
    .adv     (step),
    .n_act   (cfg.h_act),
    .n_blank (cfg.h_blank),
    .n_strb  (cfg.h_strb),
    .in_act  (h_act),
    .in_strb (h_strb),
    .at_last (h_last)
  );

  wvs_axis u_v_axis (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run_q),
    .adv     (step & h_last),
    .n_act   (cfg.v_act),
    .n_blank (cfg.v_blank),
    .n_strb  (cfg.v_strb),
    .in_act  (v_act),
    .in_strb (v_strb),
    .at_last (v_last)
  );

  wvs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run_q),
    .step      (step),
    .in_active (in_active),
    .frame_end (frame_end),
    .addr      (mem_addr)
  );

  logic [DATA_W-1:0] pix_d;
  logic              ls_d, fs_d;

  always_comb begin
    pix_d = pix_out;
    ls_d  = line_strb;
    fs_d  = frame_strb;
    if (!run_q) begin
      pix_d = '0;
      ls_d  = 1'b0;
      fs_d  = 1'b0;
    end else if (step) begin
      pix_d = in_active ? mem_rdata : '0;
      ls_d  = h_strb;
      fs_d  = v_strb;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pix_out    <= '0;
      line_strb  <= 1'b0;
      frame_strb <= 1'b0;
    end else begin
      pix_out    <= pix_d;
      line_strb  <= ls_d;
      frame_strb <= fs_d;
    end
  end
endmodule

// File: rtl/wave_streamer_chk.sv
module wave_streamer_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              pix_en,
  input logic              active,
  input logic [DATA_W-1:0] pix_out,
  input logic              hs,
  input logic              vs,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pix_out == '0) && !hs && !vs && (mem_addr == '0)); // R8

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_en) |=> $stable(pix_out) && $stable(hs) && $stable(vs) && $stable(mem_addr)); // R2

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hs || vs) |-> (pix_out == '0)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_en && active) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R1
endmodule

bind wave_streamer wave_streamer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .pix_en   (pix_en),
  .active   (in_active),
  .pix_out  (pix_out),
  .hs       (line_strb),
  .vs       (frame_strb),
  .mem_addr (mem_addr)
);

// File: tb/tb_wave_streamer.sv
module tb_wave_streamer;
  import wvs_pkg::*;

  localparam int DW   = 24;
  localparam int AW   = 6;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic          pix_en = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] pix_out;
  logic          line_strb, frame_strb;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] ad);
    logic [7:0] w;
    w = {2'b00, ad};
    return {w + 8'd1, ~w, w * 8'd3 + 8'd7};
  endfunction

  assign mem_rdata = memf(mem_addr);

  wave_streamer #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pix_en(pix_en), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .pix_out(pix_out), .line_strb(line_strb),
    .frame_strb(frame_strb)
  );

  // behavioural reference model
  int      m_run;
  int      lv[0:6];
  int      sh[0:6];
  int      h, v, a, hl, vl;
  bit      act, fend;
  logic [DW-1:0] e_pix = '0;
  bit      e_hs = 1'b0, e_vs = 1'b0;
  string   lbl = "R8";
  string   phase = "";
  int      tests = 0, fails = 0;
  bit      done = 1'b0;

  task automatic model_reset();
    m_run = 0;
    lv = '{0, 1, 1, 0, 1, 1, 0};
    sh = lv;
    h = 0; v = 0; a = 0;
    e_pix = '0; e_hs = 1'b0; e_vs = 1'b0;
    lbl = "R8";
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      if (m_run == 0) begin
        h = 0; v = 0; a = 0;
        e_pix = '0; e_hs = 1'b0; e_vs = 1'b0;
        sh = lv;
        lbl = "R8";
      end else if (pix_en) begin
        hl   = sh[1] + sh[2] - 1;
        vl   = sh[4] + sh[5] - 1;
        act  = (h < sh[1]) && (v < sh[4]);
        e_pix = act ? memf(AW'(a)) : '0;
        e_hs = (h >= sh[1]) && (h < sh[1] + sh[3]);
        e_vs = (v >= sh[4]) && (v < sh[4] + sh[6]);
        fend = (h == hl) && (v == vl);
        lbl  = e_hs ? "R3" : (e_vs ? "R4" : (act ? "R1" : "R5"));
        if (fend) begin
          a = 0; sh = lv; lbl = "R6";
        end else if (act) a = (a + 1) % MEMN;
        if (h == hl) begin
          h = 0;
          v = (v == vl) ? 0 : v + 1;
        end else h = h + 1;
      end else lbl = "R2";
      if (cfg_we) begin
        if (cfg_sel == 3'd0) m_run = int'(cfg_wdata[0]);
        else if (cfg_sel != 3'd7) lv[cfg_sel] = int'(cfg_wdata);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (pix_out !== e_pix || line_strb !== e_hs || frame_strb !== e_vs ||
          mem_addr !== AW'(a)) begin
        fails++;
        $display("FAIL %s t=%0t: pix=%h ls=%b fs=%b addr=%0d expected pix=%h ls=%b fs=%b addr=%0d",
                 (phase != "") ? phase : lbl, $time, pix_out, line_strb, frame_strb,
                 mem_addr, e_pix, e_hs, e_vs, a);
      end
    end
  end

  task automatic wr(input int sel, input int val);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = CNT_W'(val);
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic run_cycles(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      pix_en = (i % period) == 0;
    end
    @(posedge clk); #2;
    pix_en = 1'b1;
  endtask

  initial begin
    // R8: reset state is checked by the per-cycle compare
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    // R9 register map; base frame: 5+3 samples, 4+2 rows
    wr(1, 5); wr(2, 3); wr(3, 2); wr(4, 4); wr(5, 2); wr(6, 1);
    pix_en = 1'b1;
    wr(0, 1);
    run_cycles(150, 1);                 // R1 R3 R4 R5 R6
    phase = "R2";
    run_cycles(120, 3);
    phase = "R7";
    wr(1, 7); wr(4, 3);                 // mid-frame change
    run_cycles(200, 1);
    phase = "R9";
    wr(7, 0);                           // unused select: must not stop
    run_cycles(60, 1);
    phase = "R8";
    wr(0, 0);
    run_cycles(20, 1);
    phase = "";
    // wide strobe, no vertical blanking, frame larger than memory
    wr(1, 10); wr(2, 2); wr(3, 5); wr(4, 8); wr(5, 0); wr(6, 3);
    wr(0, 1);
    run_cycles(300, 1);
    phase = "R6";
    run_cycles(200, 2);
    phase = "";
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=sequence complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule